// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This block forms the memory address of a single-register load or store and the value that the base register takes if the instruction writes it back. The offset added to or subtracted from the base comes from an unsigned immediate, from a register used as-is, or from a register passed through a barrel shifter by an immediate amount. Three indexing modes decide whether the access uses the updated or the original base, and whether the base is updated at all. The unit also flags accesses whose address breaks the alignment rule for their size.

The unit sits in the address stage of a pipeline. The decode stage presents a request for one cycle with `req_valid`. One clock edge later the registered address, writeback value, writeback enable and misalignment flag appear, along with `out_valid`. When the base is the program counter, the unit reads the instruction address and adds the pipeline look-ahead of eight bytes itself.

Top module: `lsea_unit`

## Requirements
- R1: The computed value is base + offset when `sub_dir` is 0 and base − offset when `sub_dir` is 1, modulo 2^32.
- R2: With `off_src` = 0 the offset is the immediate, zero-extended. Byte (`acc_size` 0) and word (`acc_size` 2) accesses use all 12 bits of `imm_field`. Halfword (`acc_size` 1) and signed-byte (`acc_size` 3) accesses use only `imm_field[7:0]`.
- R3: With `off_src` = 1 the offset is `offset_reg` unshifted.
- R4: With `off_src` = 2 the offset is `offset_reg` shifted by `shift_amt` according to `shift_kind`: 0 shifts left with zero fill, 1 shifts right with zero fill, 2 shifts right with sign fill, 3 rotates right, and 4 rotates right by one through `carry_in` (`carry_in` enters bit 31, and `shift_amt` is ignored). For kinds 0 to 3, an amount of 0 leaves the value unchanged.
- R5: In offset mode (`idx_mode` 0, and the unused code 3), `mem_addr` = base ± offset and `wb_en` = 0.
- R6: In pre-indexed mode (`idx_mode` 1), `mem_addr` and `wb_val` both equal base ± offset, and `wb_en` = 1.
- R7: In post-indexed mode (`idx_mode` 2), `mem_addr` is the unmodified base, `wb_val` = base ± offset, and `wb_en` = 1.
- R8: When `base_is_pc` is 1, the base is `pc_val` + 8, and `base_val` has no effect on any output.
- R9: `misaligned` is 1 for a halfword access whose `mem_addr[0]` is 1, and for a word access whose `mem_addr[1:0]` is nonzero. It is never 1 for byte or signed-byte accesses.
- R10: Outputs are registered. Results appear one clock edge after `req_valid`, and `out_valid` follows `req_valid` with that one-cycle delay. While `req_valid` is 0, `mem_addr` and `wb_val` hold their values and `wb_en` and `misaligned` are 0.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented this cycle |
| base_val | input | 32 | Base register value |
| base_is_pc | input | 1 | Base is the program counter |
| pc_val | input | 32 | Address of the current instruction |
| offset_reg | input | 32 | Offset register value |
| imm_field | input | 12 | Unsigned immediate offset |
| off_src | input | 2 | Offset source: 0 immediate, 1 register, 2 shifted register |
| shift_kind | input | 3 | Shift type: 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 RRX |
| shift_amt | input | 5 | Shift amount |
| carry_in | input | 1 | Carry bit used by the one-bit extended rotate |
| sub_dir | input | 1 | 1 subtracts the offset, 0 adds it |
| idx_mode | input | 2 | 0 offset, 1 pre-indexed with writeback, 2 post-indexed |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 signed byte |
| out_valid | output | 1 | Registered results are valid |
| mem_addr | output | 32 | Access address |
| wb_val | output | 32 | New base value |
| wb_en | output | 1 | Base writeback requested |
| misaligned | output | 1 | Address breaks the size alignment rule |

## Verification
The case hardest to reach from the ports is one where several features act on the same request. Examples are a post-indexed access off the program counter that subtracts, and an extended rotate whose carry lands in the sign bit and pushes the address across the 2^31 boundary. The vector table puts each of these combinations in a single request with operand values chosen so a wrong choice shows in the result. One vector carries a bogus `base_val` together with the PC flag. Another puts garbage in the upper immediate bits of a halfword request, so that narrowing and base substitution can be seen at `mem_addr`. Directed steps then drop `req_valid` with new operands on the inputs, and pull reset in mid-stream.

// File: rtl/lsea_pkg.sv
package lsea_pkg;
  typedef enum logic [1:0] {
    SRC_IMM    = 2'd0,
    SRC_REG    = 2'd1,
    SRC_SCALED = 2'd2,
    SRC_RSVD   = 2'd3
  } off_src_e;

  typedef enum logic [2:0] {
    SH_LSL  = 3'd0,
    SH_LSR  = 3'd1,
    SH_ASR  = 3'd2,
    SH_ROR  = 3'd3,
    SH_RRX  = 3'd4,
    SH_R5   = 3'd5,
    SH_R6   = 3'd6,
    SH_R7   = 3'd7
  } shift_e;

  typedef enum logic [1:0] {
    IDX_OFFSET = 2'd0,
    IDX_PRE    = 2'd1,
    IDX_POST   = 2'd2,
    IDX_RSVD   = 2'd3
  } idx_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_SBYTE = 2'd3
  } size_e;
endpackage

// File: rtl/lsea_shifter.sv
module lsea_shifter
  import lsea_pkg::*;
#(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   val_i,
  input  shift_e         kind_i,
  input  logic [SHW-1:0] amt_i,
  input  logic           cin_i,
  output logic [W-1:0]   val_o
);
  logic [2*W-1:0] rot_dbl;

  assign rot_dbl = {val_i, val_i} >> amt_i;

  always_comb begin
    unique case (kind_i)
      SH_LSL:  val_o = val_i << amt_i;
      SH_LSR:  val_o = val_i >> amt_i;
      SH_ASR:  val_o = W'($signed(val_i) >>> amt_i);
      SH_ROR:  val_o = rot_dbl[W-1:0];
      SH_RRX:  val_o = {cin_i, val_i[W-1:1]};
      default: val_o = val_i;
    endcase
  end
endmodule

// File: rtl/lsea_offset_sel.sv
module lsea_offset_sel
  import lsea_pkg::*;
#(
  parameter int W        = 32,
  parameter int IMM_W    = 12,
  parameter int NARROW_W = 8
) (
  input  off_src_e         src_i,
  input  size_e            size_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [W-1:0]     reg_i,
  input  logic [W-1:0]     shifted_i,
  output logic [W-1:0]     offset_o
);
  logic          narrow;
  logic [W-1:0]  imm_wide;
  logic [W-1:0]  imm_short;

  assign narrow    = (size_i == SZ_HALF) || (size_i == SZ_SBYTE);
  assign imm_wide  = {{(W-IMM_W){1'b0}}, imm_i};
  assign imm_short = {{(W-NARROW_W){1'b0}}, imm_i[NARROW_W-1:0]};

  always_comb begin
    unique case (src_i)
      SRC_IMM:    offset_o = narrow ? imm_short : imm_wide;
      SRC_REG:    offset_o = reg_i;
      SRC_SCALED: offset_o = shifted_i;
      default:    offset_o = reg_i;
    endcase
  end
endmodule

// File: rtl/lsea_addr_gen.sv
module lsea_addr_gen
  import lsea_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] offset_i,
  input  logic         sub_i,
  input  idx_e         mode_i,
  input  size_e        size_i,
  output logic [W-1:0] addr_o,
  output logic [W-1:0] wb_o,
  output logic         wb_en_o,
  output logic         mis_o
);
  logic [W-1:0] moved;

  assign moved = sub_i ? (base_i - offset_i) : (base_i + offset_i);
  assign wb_o  = moved;

  always_comb begin
    unique case (mode_i)
      IDX_PRE: begin
        addr_o  = moved;
        wb_en_o = 1'b1;
      end
      IDX_POST: begin
        addr_o  = base_i;
        wb_en_o = 1'b1;
      end
      default: begin
        addr_o  = moved;
        wb_en_o = 1'b0;
      end
    endcase
  end

  always_comb begin
    unique case (size_i)
      SZ_HALF: mis_o = addr_o[0];
      SZ_WORD: mis_o = |addr_o[1:0];
      default: mis_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsea_unit.sv
module lsea_unit
  import lsea_pkg::*;
#(
  parameter int AW       = 32,
  parameter int IMM_W    = 12,
  parameter int NARROW_W = 8,
  parameter int PC_AHEAD = 8,
  localparam int SHW     = $clog2(AW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AW-1:0]    base_val,
  input  logic             base_is_pc,
  input  logic [AW-1:0]    pc_val,
  input  logic [AW-1:0]    offset_reg,
  input  logic [IMM_W-1:0] imm_field,
  input  logic [1:0]       off_src,
  input  logic [2:0]       shift_kind,
  input  logic [SHW-1:0]   shift_amt,
  input  logic             carry_in,
  input  logic             sub_dir,
  input  logic [1:0]       idx_mode,
  input  logic [1:0]       acc_size,
  output logic             out_valid,
  output logic [AW-1:0]    mem_addr,
  output logic [AW-1:0]    wb_val,
  output logic             wb_en,
  output logic             misaligned
);
  logic [AW-1:0] base_eff;
  logic [AW-1:0] shifted;
  logic [AW-1:0] offset;
  logic [AW-1:0] addr_c, wb_c;
  logic          wb_en_c, mis_c;

  logic [AW-1:0] addr_d, wb_d;
  logic          valid_d, wb_en_d, mis_d;

  assign base_eff = base_is_pc ? (pc_val + AW'(PC_AHEAD)) : base_val;

  lsea_shifter #(.W(AW)) u_shift (
    .val_i  (offset_reg),
    .kind_i (shift_e'(shift_kind)),
    .amt_i  (shift_amt),
    .cin_i  (carry_in),
    .val_o  (shifted)
  );

  lsea_offset_sel #(.W(AW), .IMM_W(IMM_W), .NARROW_W(NARROW_W)) u_osel (
    .src_i     (off_src_e'(off_src)),
    .size_i    (size_e'(acc_size)),
    .imm_i     (imm_field),
    .reg_i     (offset_reg),
    .shifted_i (shifted),
    .offset_o  (offset)
  );

  lsea_addr_gen #(.W(AW)) u_agen (
    .base_i   (base_eff),
    .offset_i (offset),
    .sub_i    (sub_dir),
    .mode_i   (idx_e'(idx_mode)),
    .size_i   (size_e'(acc_size)),
    .addr_o   (addr_c),
    .wb_o     (wb_c),
    .wb_en_o  (wb_en_c),
    .mis_o    (mis_c)
  );

  // next-state
  always_comb begin
    valid_d = req_valid;
    addr_d  = mem_addr;
    wb_d    = wb_val;
    wb_en_d = 1'b0;
    mis_d   = 1'b0;
    if (req_valid) begin
      addr_d  = addr_c;
      wb_d    = wb_c;
      wb_en_d = wb_en_c;
      mis_d   = mis_c;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      mem_addr   <= '0;
      wb_val     <= '0;
      wb_en      <= 1'b0;
      misaligned <= 1'b0;
    end else begin
      out_valid  <= valid_d;
      mem_addr   <= addr_d;
      wb_val     <= wb_d;
      wb_en      <= wb_en_d;
      misaligned <= mis_d;
    end
  end

  // R5
  offset_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (idx_mode == 2'd0 || idx_mode == 2'd3)) |=> !wb_en);

  // R6
  pre_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && idx_mode == 2'd1) |=> (wb_en && mem_addr == wb_val));

  // R7
  post_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && idx_mode == 2'd2 && !base_is_pc) |=> (wb_en && mem_addr == $past(base_val)));

  // R9
  byte_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (acc_size == 2'd0 || acc_size == 2'd3)) |=> !misaligned);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && !wb_en && !misaligned && $stable(mem_addr) && $stable(wb_val)));

  // R2
  narrow_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (off_src == 2'd0 && (acc_size == 2'd1 || acc_size == 2'd3)) |-> (offset < AW'(1 << NARROW_W)));
endmodule

// File: tb/test_lsea_unit.sv
module test_lsea_unit;
  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  size;
    logic [1:0]  src;
    logic [2:0]  kind;
    logic [4:0]  amt;
    logic        cin;
    logic        sub;
    logic        is_pc;
    logic [31:0] base;
    logic [31:0] pc;
    logic [31:0] rg;
    logic [11:0] imm;
    logic [31:0] e_addr;
    logic [31:0] e_wb;
    logic        e_wbe;
    logic        e_mis;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    // R1 R5 immediate add, word
    '{2'd0,2'd2,2'd0,3'd0,5'd0,1'b0,1'b0,1'b0,32'h1000,32'h0,32'h0,12'h010,32'h1010,32'h1010,1'b0,1'b0},
    // R1 R6 pre-indexed subtract
    '{2'd1,2'd2,2'd0,3'd0,5'd0,1'b0,1'b1,1'b0,32'h2000,32'h0,32'h0,12'h0FC,32'h1F04,32'h1F04,1'b1,1'b0},
    // R7 R2 post-indexed, full 12-bit immediate, byte
    '{2'd2,2'd0,2'd0,3'd0,5'd0,1'b0,1'b0,1'b0,32'h0300,32'h0,32'h0,12'hFFF,32'h0300,32'h12FF,1'b1,1'b0},
    // R2 halfword narrows immediate
    '{2'd0,2'd1,2'd0,3'd0,5'd0,1'b0,1'b0,1'b0,32'h0100,32'h0,32'h0,12'hF22,32'h0122,32'h0122,1'b0,1'b0},
    // R9 halfword odd address
    '{2'd0,2'd1,2'd0,3'd0,5'd0,1'b0,1'b0,1'b0,32'h0100,32'h0,32'h0,12'h021,32'h0121,32'h0121,1'b0,1'b1},
    // R3 R9 register offset, word misaligned
    '{2'd0,2'd2,2'd1,3'd0,5'd9,1'b0,1'b0,1'b0,32'h4000,32'h0,32'h6,12'hFFF,32'h4006,32'h4006,1'b0,1'b1},
    // R4 LSL 2
    '{2'd0,2'd2,2'd2,3'd0,5'd2,1'b0,1'b0,1'b0,32'h1000,32'h0,32'h3,12'h0,32'h100C,32'h100C,1'b0,1'b0},
    // R4 LSR 4 subtract
    '{2'd0,2'd2,2'd2,3'd1,5'd4,1'b0,1'b1,1'b0,32'h1000,32'h0,32'h100,12'h0,32'h0FF0,32'h0FF0,1'b0,1'b0},
    // R4 ASR 4 subtract
    '{2'd0,2'd0,2'd2,3'd2,5'd4,1'b0,1'b1,1'b0,32'h0,32'h0,32'h80000000,12'h0,32'h08000000,32'h08000000,1'b0,1'b0},
    // R4 ROR 8
    '{2'd1,2'd0,2'd2,3'd3,5'd8,1'b0,1'b0,1'b0,32'h0,32'h0,32'hAB,12'h0,32'hAB000000,32'hAB000000,1'b1,1'b0},
    // R4 RRX carry into bit 31, amount ignored, halfword
    '{2'd0,2'd1,2'd2,3'd4,5'd7,1'b1,1'b0,1'b0,32'h10,32'h0,32'h4,12'h0,32'h80000012,32'h80000012,1'b0,1'b0},
    // R8 PC base, bogus base_val
    '{2'd0,2'd2,2'd0,3'd0,5'd0,1'b0,1'b0,1'b1,32'hDEAD,32'h8000,32'h0,12'h040,32'h8048,32'h8048,1'b0,1'b0},
    // R2 signed byte narrows immediate
    '{2'd0,2'd3,2'd0,3'd0,5'd0,1'b0,1'b0,1'b0,32'h10,32'h0,32'h0,12'h1FF,32'h010F,32'h010F,1'b0,1'b0},
    // R7 R8 post-indexed off PC, subtract
    '{2'd2,2'd2,2'd0,3'd0,5'd0,1'b0,1'b1,1'b1,32'h5555,32'h100,32'h0,12'h004,32'h0108,32'h0104,1'b1,1'b0},
    // R4 R5 amount zero unchanged, reserved mode 3 acts as offset
    '{2'd3,2'd0,2'd2,3'd0,5'd0,1'b0,1'b0,1'b0,32'h0,32'h0,32'h5,12'h0,32'h5,32'h5,1'b0,1'b0}
  };

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] base_val;
  logic        base_is_pc;
  logic [31:0] pc_val;
  logic [31:0] offset_reg;
  logic [11:0] imm_field;
  logic [1:0]  off_src;
  logic [2:0]  shift_kind;
  logic [4:0]  shift_amt;
  logic        carry_in;
  logic        sub_dir;
  logic [1:0]  idx_mode;
  logic [1:0]  acc_size;
  logic        out_valid;
  logic [31:0] mem_addr;
  logic [31:0] wb_val;
  logic        wb_en;
  logic        misaligned;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  lsea_unit i_lsea_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_val(base_val),
    .base_is_pc(base_is_pc), .pc_val(pc_val), .offset_reg(offset_reg),
    .imm_field(imm_field), .off_src(off_src), .shift_kind(shift_kind),
    .shift_amt(shift_amt), .carry_in(carry_in), .sub_dir(sub_dir),
    .idx_mode(idx_mode), .acc_size(acc_size), .out_valid(out_valid),
    .mem_addr(mem_addr), .wb_val(wb_val), .wb_en(wb_en), .misaligned(misaligned)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    req_valid  = 1'b1;
    idx_mode   = v.mode;
    acc_size   = v.size;
    off_src    = v.src;
    shift_kind = v.kind;
    shift_amt  = v.amt;
    carry_in   = v.cin;
    sub_dir    = v.sub;
    base_is_pc = v.is_pc;
    base_val   = v.base;
    pc_val     = v.pc;
    offset_reg = v.rg;
    imm_field  = v.imm;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    apply(VECS[0]);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 out_valid", {31'b0, out_valid}, 32'h0);
    check("R11 mem_addr", mem_addr, 32'h0);
    check("R11 wb_val", wb_val, 32'h0);
    check("R11 wb_en", {31'b0, wb_en}, 32'h0);
    check("R11 misaligned", {31'b0, misaligned}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      @(negedge clk);
      // R10 one-cycle latency; R1..R9 per table comment
      check($sformatf("R10 vec%0d out_valid", i), {31'b0, out_valid}, 32'h1);
      check($sformatf("R1 vec%0d mem_addr", i), mem_addr, VECS[i].e_addr);
      check($sformatf("R6 vec%0d wb_val", i), wb_val, VECS[i].e_wb);
      check($sformatf("R5 vec%0d wb_en", i), {31'b0, wb_en}, {31'b0, VECS[i].e_wbe});
      check($sformatf("R9 vec%0d misaligned", i), {31'b0, misaligned}, {31'b0, VECS[i].e_mis});
    end

    // R10 idle: new operands presented without req_valid must not reach outputs
    apply(VECS[4]);
    req_valid = 1'b0;
    @(negedge clk);
    check("R10 idle out_valid", {31'b0, out_valid}, 32'h0);
    check("R10 idle mem_addr hold", mem_addr, 32'h5);
    check("R10 idle wb_val hold", wb_val, 32'h5);
    check("R10 idle wb_en", {31'b0, wb_en}, 32'h0);
    check("R10 idle misaligned", {31'b0, misaligned}, 32'h0);

    // R8 base_val has no effect with PC base: same request, different base_val
    apply(VECS[11]);
    base_val = 32'h0BAD_0000;
    @(negedge clk);
    check("R8 pc base ignores base_val", mem_addr, 32'h8048);

    // R11 reset mid-stream clears outputs asynchronously
    apply(VECS[1]);
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    check("R11 async out_valid", {31'b0, out_valid}, 32'h0);
    check("R11 async mem_addr", mem_addr, 32'h0);
    check("R11 async wb_en", {31'b0, wb_en}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    req_valid = 1'b0;
    @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule